// File: doc/BRIEF.md
# Scrambled DC-Balanced Word Framer

This block prepares 32-bit parallel payload words for a serial link and recovers them on the far side. On the transmit path each accepted word passes through four stages in a fixed order. An additive scrambler whitens it. A running-disparity balancer then decides whether to send it inverted. A transition limiter XORs it with an alternating mask when it toggles too often. Finally the framer wraps it in a 36-bit line word. That line word has a fixed high start bit and a fixed low stop bit, so every word carries at least one edge.

The receive path takes 36-bit line words. It checks the two clock bits, removes the mask and the inversion as the in-band flags direct, and descrambles with its own keystream generator. Both generators restart from the same seed on reset. With an error-free link, the receive output reproduces the transmit input word for word.

The transmit balancer keeps its decision state in an enumerated state machine with three states. `RD_EVEN` means the running total is zero. `RD_HIGH` means the total is positive. `RD_LOW` means it is negative. After every accepted word the next state is chosen from the sign of the updated total. The transitions are `RD_EVEN->RD_HIGH`, `RD_EVEN->RD_LOW`, `RD_HIGH->RD_EVEN`, `RD_HIGH->RD_LOW`, `RD_LOW->RD_EVEN` and `RD_LOW->RD_HIGH`, and each state may also stay where it is.

The receive side has a three-state output machine. `RX_IDLE` means no word arrived. `RX_GOOD` means a word arrived with correct clock bits. `RX_BAD` means a word arrived with a clock-bit fault. From any state, the next cycle's state is chosen by `rx_valid` and by the clock-bit check.

Top module: `word_framer`

## Requirements
- R1: A word accepted with `tx_valid` high at a rising edge appears on `line_word` after that same edge, with `line_valid` high for exactly that cycle.
- R2: The line word layout is as follows. Bit 35 is 1 (start clock bit), bit 34 is the invert flag, bit 33 is the shuffle flag, bits 32:1 are the processed payload, and bit 0 is 0 (stop clock bit).
- R3: The scrambler key comes from a 16-bit register s, seeded to 0xFFFF on reset. Each key bit, from bit 31 down to bit 0, is s[15], after which s shifts left taking s[15]^s[4]^s[3]^s[2] into bit 0. The key is XORed onto the payload. The register advances by 32 steps only on accepted words, and both sides restart from the seed on every reset.
- R4: The disparity of a word is its count of ones minus its count of zeros. The running total starts at 0. The scrambled word is inverted, and the invert flag set, when both its disparity and the running total are nonzero and share a sign. The disparity of the word after that decision is then added to the total.
- R5: Transitions are the unequal neighbours among the 31 adjacent bit pairs of the balanced word. When the count is above 20, the word is XORed with 0x55555555 and the shuffle flag set. At exactly 20 the word is sent unmasked.
- R6: The receiver takes `rx_word` with `rx_valid` and presents the recovered word on `rx_out_data` after one edge, with `rx_out_valid` high for that cycle. Looped back, the recovered word equals the transmitted input.
- R7: `rx_frame_err` is high together with `rx_out_valid` when bit 35 of the received word is not 1 or bit 0 is not 0. The payload is still decoded and the receive keystream still advances.
- R8: During and right after reset, `line_valid`, `line_word`, `rx_out_valid`, `rx_out_data` and `rx_frame_err` are all zero.
- R9: In a cycle with no input valid on a side, that side's valid output is low, `rx_frame_err` is low, and the data outputs hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Transmit payload present |
| tx_data | input | 32 | Transmit payload |
| line_valid | output | 1 | Line word produced this cycle |
| line_word | output | 36 | Framed line word |
| rx_valid | input | 1 | Received line word present |
| rx_word | input | 36 | Received line word |
| rx_out_valid | output | 1 | Recovered payload present |
| rx_out_data | output | 32 | Recovered payload |
| rx_frame_err | output | 1 | Clock-bit fault on the word just decoded |

## Verification
A keystream that advanced on an idle cycle, or missed a step, corrupts every later line word. It also breaks the loopback comparison from the next decoded word onward. A wrong balancer state flips the invert flag of the first word whose disparity shares the wrongly held sign, and bit 34 shows this on the very next line word. A wrong limiter threshold or mask shows only on words near 20 transitions, so directed words at 20 and 21 transitions expose it in one cycle. Receive-side state errors show as a wrong `rx_frame_err` or a missing `rx_out_valid` one edge after the offending input.

// File: rtl/framer_pkg.sv
package framer_pkg;
    localparam int unsigned PAY_W    = 32;
    localparam int unsigned LINE_W   = PAY_W + 4;
    localparam int unsigned LFSR_W   = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hFFFF;
    localparam int unsigned RD_W     = $clog2(PAY_W) + 3;

    typedef enum logic [1:0] {RD_EVEN, RD_HIGH, RD_LOW} rd_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_GOOD, RX_BAD} rx_state_t;

    function automatic logic [PAY_W-1:0] alt_mask();
        logic [PAY_W-1:0] m;
        for (int i = 0; i < PAY_W; i++) m[i] = (i % 2 == 0);
        return m;
    endfunction

    function automatic int ones_of(input logic [PAY_W-1:0] v);
        int n = 0;
        for (int i = 0; i < PAY_W; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic int edges_of(input logic [PAY_W-1:0] v);
        int n = 0;
        for (int i = 1; i < PAY_W; i++) n += int'(v[i] ^ v[i-1]);
        return n;
    endfunction
endpackage

// File: rtl/lfsr_keystream.sv
module lfsr_keystream
    import framer_pkg::*;
#(
    parameter int unsigned KEY_W = PAY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [KEY_W-1:0] key
);
    logic [LFSR_W-1:0] st_q;
    logic [LFSR_W-1:0] chain [KEY_W+1];

    assign chain[0] = st_q;

    for (genvar i = 0; i < KEY_W; i++) begin : g_step
        assign key[KEY_W-1-i] = chain[i][LFSR_W-1];
        assign chain[i+1] = {chain[i][LFSR_W-2:0],
                             chain[i][15] ^ chain[i][4] ^ chain[i][3] ^ chain[i][2]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       st_q <= LFSR_SEED;
        else if (advance) st_q <= chain[KEY_W];
    end
endmodule

// File: rtl/word_encoder.sv
module word_encoder
    import framer_pkg::*;
#(
    parameter int SHUF_LIMIT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PAY_W-1:0]  in_data,
    output logic              out_valid,
    output logic [LINE_W-1:0] out_word
);
    localparam logic [PAY_W-1:0] MASK = alt_mask();

    rd_state_t               rd_state_q, rd_state_d;
    logic signed [RD_W-1:0]  rd_q, rd_d;
    logic [PAY_W-1:0]        key, scr, bal, pay;
    logic                    inv, shuf;
    logic                    valid_q;
    logic [LINE_W-1:0]       word_q;
    int                      sdisp, bdisp, total;

    lfsr_keystream #(.KEY_W(PAY_W)) u_ks (
        .clk(clk), .rst_n(rst_n), .advance(in_valid), .key(key)
    );

    always_comb begin
        scr   = in_data ^ key;
        sdisp = 2 * ones_of(scr) - int'(PAY_W);
        unique case (rd_state_q)
            RD_EVEN: inv = 1'b0;
            RD_HIGH: inv = (sdisp > 0);
            RD_LOW:  inv = (sdisp < 0);
            default: inv = 1'b0;
        endcase
        bal   = inv ? ~scr : scr;
        bdisp = 2 * ones_of(bal) - int'(PAY_W);
        total = int'(rd_q) + bdisp;
        rd_d  = RD_W'(total);
        if (total > 0)      rd_state_d = RD_HIGH;
        else if (total < 0) rd_state_d = RD_LOW;
        else                rd_state_d = RD_EVEN;
        shuf  = edges_of(bal) > SHUF_LIMIT;
        pay   = shuf ? (bal ^ MASK) : bal;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_state_q <= RD_EVEN;
            rd_q       <= '0;
        end else if (in_valid) begin
            rd_state_q <= rd_state_d;
            rd_q       <= rd_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            word_q  <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) word_q <= {1'b1, inv, shuf, pay, 1'b0};
        end
    end

    assign out_valid = valid_q;
    assign out_word  = word_q;
endmodule

// File: rtl/word_decoder.sv
module word_decoder
    import framer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [LINE_W-1:0] in_word,
    output logic              out_valid,
    output logic [PAY_W-1:0]  out_data,
    output logic              frame_err
);
    localparam logic [PAY_W-1:0] MASK = alt_mask();

    rx_state_t        st_q, st_d;
    logic [PAY_W-1:0] key, unshuf, plain, data_q;
    logic             bad;

    lfsr_keystream #(.KEY_W(PAY_W)) u_ks (
        .clk(clk), .rst_n(rst_n), .advance(in_valid), .key(key)
    );

    always_comb begin
        bad    = (in_word[LINE_W-1] != 1'b1) || (in_word[0] != 1'b0);
        unshuf = in_word[LINE_W-3] ? (in_word[PAY_W:1] ^ MASK) : in_word[PAY_W:1];
        plain  = (in_word[LINE_W-2] ? ~unshuf : unshuf) ^ key;
        if (!in_valid) st_d = RX_IDLE;
        else if (bad)  st_d = RX_BAD;
        else           st_d = RX_GOOD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= RX_IDLE;
            data_q <= '0;
        end else begin
            st_q <= st_d;
            if (in_valid) data_q <= plain;
        end
    end

    always_comb begin
        unique case (st_q)
            RX_IDLE: begin out_valid = 1'b0; frame_err = 1'b0; end
            RX_GOOD: begin out_valid = 1'b1; frame_err = 1'b0; end
            RX_BAD:  begin out_valid = 1'b1; frame_err = 1'b1; end
            default: begin out_valid = 1'b0; frame_err = 1'b0; end
        endcase
    end

    assign out_data = data_q;
endmodule

// File: rtl/word_framer.sv
module word_framer
    import framer_pkg::*;
#(
    parameter int SHUF_LIMIT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [PAY_W-1:0]  tx_data,
    output logic              line_valid,
    output logic [LINE_W-1:0] line_word,
    input  logic              rx_valid,
    input  logic [LINE_W-1:0] rx_word,
    output logic              rx_out_valid,
    output logic [PAY_W-1:0]  rx_out_data,
    output logic              rx_frame_err
);
    word_encoder #(.SHUF_LIMIT(SHUF_LIMIT)) u_enc (
        .clk(clk), .rst_n(rst_n),
        .in_valid(tx_valid), .in_data(tx_data),
        .out_valid(line_valid), .out_word(line_word)
    );

    word_decoder u_dec (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rx_valid), .in_word(rx_word),
        .out_valid(rx_out_valid), .out_data(rx_out_data),
        .frame_err(rx_frame_err)
    );
endmodule

// File: rtl/framer_checker.sv
module framer_checker
    import framer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tx_valid,
    input logic [PAY_W-1:0]  tx_data,
    input logic              line_valid,
    input logic [LINE_W-1:0] line_word,
    input logic              rx_valid,
    input logic [LINE_W-1:0] rx_word,
    input logic              rx_out_valid,
    input logic [PAY_W-1:0]  rx_out_data,
    input logic              rx_frame_err
);
    localparam logic [PAY_W-1:0] CMASK = alt_mask();

    function automatic int tog(input logic [PAY_W-1:0] v);
        int n = 0;
        for (int i = 0; i + 1 < PAY_W; i++) if (v[i] != v[i+1]) n++;
        return n;
    endfunction

    a_r1_line_follows_tx: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> line_valid);

    a_r2_clock_bits: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> (line_word[LINE_W-1] == 1'b1 && line_word[0] == 1'b0));

    a_r5_shuffle_flag: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> (line_word[LINE_W-3] ==
            (tog(line_word[PAY_W:1] ^ (line_word[LINE_W-3] ? CMASK : '0)) > 20)));

    a_r6_rx_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rx_out_valid);

    a_r7_frame_err: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (rx_word[LINE_W-1] != 1'b1 || rx_word[0] != 1'b0))
        |=> (rx_frame_err && rx_out_valid));

    a_r9_tx_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |=> (!line_valid && $stable(line_word)));

    a_r9_rx_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> (!rx_out_valid && !rx_frame_err && $stable(rx_out_data)));
endmodule

bind word_framer framer_checker u_chk (.*);

// File: tb/word_framer_tb.sv
module word_framer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_valid = 1'b0;
    logic [31:0] tx_data = '0;
    logic        line_valid;
    logic [35:0] line_word;
    logic        rx_valid;
    logic [35:0] rx_word;
    logic        rx_out_valid;
    logic [31:0] rx_out_data;
    logic        rx_frame_err;
    logic [35:0] corrupt = '0;

    always #4 clk = ~clk;

    assign rx_valid = line_valid;
    assign rx_word  = line_word ^ corrupt;

    word_framer u_dut (.*);

    int n_chk = 0, n_fail = 0;
    logic [15:0] m_s;
    int          m_rd;
    logic        exp_lv, exp_ov, exp_err;
    logic [35:0] exp_lw;
    logic [31:0] exp_od;
    logic [31:0] sent_q[$];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] key_of(input logic [15:0] s);
        logic [31:0] k;
        for (int i = 31; i >= 0; i--) begin
            k[i] = s[15];
            s = {s[14:0], s[15] ^ s[4] ^ s[3] ^ s[2]};
        end
        return k;
    endfunction

    function automatic logic [15:0] adv_of(input logic [15:0] s);
        for (int i = 0; i < 32; i++) s = {s[14:0], s[15] ^ s[4] ^ s[3] ^ s[2]};
        return s;
    endfunction

    function automatic int pop(input logic [31:0] v);
        int n = 0;
        for (int i = 0; i < 32; i++) if (v[i]) n++;
        return n;
    endfunction

    task automatic model_encode(input logic [31:0] d, output logic [35:0] w);
        logic [31:0] scr, bal, pay;
        int disp, trans;
        logic inv, sh;
        scr  = d ^ key_of(m_s);
        m_s  = adv_of(m_s);
        disp = 2 * pop(scr) - 32;
        inv  = (m_rd > 0 && disp > 0) || (m_rd < 0 && disp < 0);
        bal  = inv ? ~scr : scr;
        m_rd = m_rd + 2 * pop(bal) - 32;
        trans = 0;
        for (int i = 0; i < 31; i++) if (bal[i] != bal[i+1]) trans++;
        sh   = trans > 20;
        pay  = sh ? (bal ^ 32'h5555_5555) : bal;
        w    = {1'b1, inv, sh, pay, 1'b0};
    endtask

    // one cycle: compare every output, then drive the next inputs
    task automatic step(input logic v, input logic [31:0] d, input logic [35:0] c);
        logic [35:0] w;
        @(negedge clk);
        chk("R1 line_valid", 64'(line_valid), 64'(exp_lv));
        chk("R2/R3/R4/R5 line_word", 64'(line_word), 64'(exp_lw));
        chk("R6 rx_out_valid", 64'(rx_out_valid), 64'(exp_ov));
        chk("R6 rx_out_data", 64'(rx_out_data), 64'(exp_od));
        chk("R7/R9 rx_frame_err", 64'(rx_frame_err), 64'(exp_err));
        if (exp_lv) begin
            exp_ov  = 1'b1;
            exp_od  = sent_q.pop_front();
            exp_err = (c[35] | c[0]);
            corrupt = c;
        end else begin
            exp_ov  = 1'b0;
            exp_err = 1'b0;
            corrupt = '0;
        end
        if (v) begin
            model_encode(d, w);
            exp_lv = 1'b1;
            exp_lw = w;
            sent_q.push_back(d);
        end else begin
            exp_lv = 1'b0;
        end
        tx_valid = v;
        tx_data  = d;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tx_valid = 1'b0; corrupt = '0;
        repeat (3) @(negedge clk);
        chk("R8 line_valid reset", 64'(line_valid), 64'd0);
        chk("R8 line_word reset", 64'(line_word), 64'd0);
        chk("R8 rx outputs reset", {31'd0, rx_out_valid, rx_out_data}, 64'd0);
        chk("R8 rx_frame_err reset", 64'(rx_frame_err), 64'd0);
        m_s = 16'hFFFF; m_rd = 0;
        exp_lv = 0; exp_lw = '0; exp_ov = 0; exp_od = '0; exp_err = 0;
        sent_q.delete();
        rst_n = 1'b1;
    endtask

    task automatic send_scr(input logic [31:0] target);
        step(1'b1, target ^ key_of(m_s), '0);
    endtask

    bit done = 0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired, R1 actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] first_d;
        do_reset();
        step(1'b0, '0, '0);
        first_d = 32'hFFFF_FFFF ^ key_of(m_s);
        send_scr(32'hFFFF_FFFF);
        step(1'b0, '0, '0);
        chk("R2 R4 first word no invert", 64'(line_word), 64'(36'h9_FFFF_FFFE));
        send_scr(32'hFFFF_FFFF);
        step(1'b0, '0, '0);
        chk("R4 same-sign word inverted", 64'(line_word), 64'(36'hC_0000_0000));
        send_scr(32'hAAAA_AAAA);
        step(1'b0, '0, '0);
        chk("R5 31 transitions masked", 64'(line_word), 64'(36'hB_FFFF_FFFE));
        send_scr(32'h5555_5000);
        step(1'b0, '0, '0);
        chk("R5 exactly 20 transitions unmasked", 64'(line_word), 64'(36'h8_AAAA_A000));
        send_scr(32'h5555_500F);
        step(1'b0, '0, '0);
        chk("R4 R5 inverted and masked", 64'(line_word), 64'(36'hF_FFFF_F54A));
        repeat (3) step(1'b0, '0, '0);
        chk("R9 idle holds line_word", 64'(line_word), 64'(36'hF_FFFF_F54A));

        for (int n = 0; n < 400; n++) begin
            logic [35:0] c;
            c = '0;
            if ($urandom_range(0, 9) == 0) c[35] = 1'b1;
            if ($urandom_range(0, 9) == 0) c[0]  = 1'b1;
            step($urandom_range(0, 3) != 0, $urandom, c);
        end
        repeat (3) step(1'b0, '0, '0);

        do_reset();
        step(1'b1, first_d, '0);
        step(1'b0, '0, '0);
        chk("R3 keystream restarts after reset", 64'(line_word), 64'(36'h9_FFFF_FFFE));
        for (int n = 0; n < 50; n++) step(1'b1, $urandom, '0);
        repeat (3) step(1'b0, '0, '0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule